// File: doc/BRIEF.md
# Infrared SIR Receive Pulse Stretcher

This block sits between an infrared receiver and the receive input of a UART. The infrared receive line idles high. Each incoming pulse pulls it low for a short time: either 3/16 of a bit time or a fixed width of about 1.63 µs. The block turns every such pulse into one full bit time of space (logic 0) on its serial receive output, so the UART sees ordinary NRZ data. All logic runs on a clock at sixteen times the baud rate.

The line first passes through a synchronizer. A falling edge of the synchronized level starts a down-counter that holds the output low for one bit time. Only a falling edge starts a stretch; a level that stays low does not. A new falling edge during a stretch reloads the counter, so consecutive zero bits merge into one unbroken low level. Active-low reset clears the counter and returns the output to mark.

Top module: `sir_pulse_decoder`

## Requirements
- R1: While `rst_n` is low, `rxd` is high and no stretch is pending. This holds at once, without waiting for a clock edge.
- R2: Suppose `ir_rx` is high at one rising edge of `clk_16x` and low at the next edge, call it E0. Then `rxd` goes low just after rising edge E0+2: two synchronizer stages plus the stretch register.
- R3: A stretch holds `rxd` low for exactly `BIT_CYCLES` (default 16) clock periods. `rxd` returns high just after edge E0+2+`BIT_CYCLES`.
- R4: A 3/16-bit-time pulse (`ir_rx` low for 3 clock periods) produces exactly one stretch.
- R5: A short fixed-width pulse that is low at only one rising edge of `clk_16x` still produces a full stretch.
- R6: An `ir_rx` level held low for longer than a bit time produces a single stretch. The low level does not lengthen the stretch or start it again.
- R7: A falling edge that arrives during a stretch reloads the full count from that edge. Pulses one bit time or less apart therefore give one continuous low level on `rxd`, which ends `BIT_CYCLES` periods after the last pulse's stretch begins.
- R8: A rising edge on `ir_rx`, or an idle line, never drives `rxd` low and leaves a running count to run down unchanged.
- R9: Asserting `rst_n` in the middle of a stretch forces `rxd` high at once. After reset is released, `rxd` stays high until a new falling edge arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_16x | input | 1 | Sampling clock at 16 times the baud rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| ir_rx | input | 1 | Infrared receive line, idles high; pulses are active low |
| rxd | output | 1 | NRZ receive data for the UART, idles high |

## Verification
Each result is due a fixed number of rising edges after the edge at which the new `ir_rx` level is first sampled. `rxd` falls after the second edge and rises again `BIT_CYCLES` edges later. Reset takes effect without a clock. The bench drives `ir_rx` on falling clock edges and counts rising edges itself. It keeps the edge numbers of the last two falling edges it drove, and from those it predicts `rxd` for every cycle. It compares the output on every falling edge, so an error of a single cycle at either end of a stretch is caught.

// File: rtl/sir_dec_pkg.sv
package sir_dec_pkg;

  // Next value of the stretch down-counter: reload on a falling edge,
  // otherwise count down to zero and hold there.
  function automatic int unsigned stretch_next(input int unsigned cur,
                                               input logic        fall,
                                               input int unsigned reload);
    if (fall)
      return reload;
    else if (cur != 0)
      return cur - 1;
    else
      return 0;
  endfunction

  // Output level for a given count: space while counting, mark at zero.
  function automatic logic line_level(input int unsigned cur);
    return (cur == 0);
  endfunction

endpackage

// File: rtl/sir_in_sync.sv
module sir_in_sync #(
  parameter int unsigned STAGES   = 2,
  parameter logic        IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          chain[i] <= IDLE_LVL;
        else if (i == 0)
          chain[i] <= d_async;
        else
          chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/sir_edge_det.sv
module sir_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic fall
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lvl_q <= 1'b1;
    else
      lvl_q <= lvl;
  end

  assign fall = lvl_q & ~lvl;
endmodule

// File: rtl/sir_stretch_ctr.sv
module sir_stretch_ctr
  import sir_dec_pkg::*;
#(
  parameter int unsigned BIT_CYCLES = 16,
  localparam int unsigned CW        = $clog2(BIT_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fall,
  output logic [CW-1:0] cnt,
  output logic          line
);
  logic [CW-1:0] cnt_d;

  always_comb
    cnt_d = CW'(stretch_next(32'(cnt), fall, BIT_CYCLES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else
      cnt <= cnt_d;
  end

  assign line = line_level(32'(cnt));
endmodule

// File: rtl/sir_pulse_decoder.sv
module sir_pulse_decoder #(
  parameter int unsigned BIT_CYCLES  = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CW         = $clog2(BIT_CYCLES + 1)
) (
  input  logic clk_16x,
  input  logic rst_n,
  input  logic ir_rx,
  output logic rxd
);
  // Named internal events, exposed for the bound checker.
  logic          ir_sync;
  logic          fall_evt;
  logic [CW-1:0] stretch_cnt;

  sir_in_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_sync (
    .clk     (clk_16x),
    .rst_n   (rst_n),
    .d_async (ir_rx),
    .q_sync  (ir_sync)
  );

  sir_edge_det u_edge (
    .clk   (clk_16x),
    .rst_n (rst_n),
    .lvl   (ir_sync),
    .fall  (fall_evt)
  );

  sir_stretch_ctr #(.BIT_CYCLES(BIT_CYCLES)) u_ctr (
    .clk   (clk_16x),
    .rst_n (rst_n),
    .fall  (fall_evt),
    .cnt   (stretch_cnt),
    .line  (rxd)
  );
endmodule

// File: rtl/sir_pulse_decoder_chk.sv
module sir_pulse_decoder_chk #(
  parameter int unsigned BIT_CYCLES = 16,
  parameter int unsigned CW         = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rxd,
  input logic          fall_evt,
  input logic [CW-1:0] cnt
);
  // R1: mark held while in reset
  p_reset_mark_r1: assert property (@(posedge clk) !rst_n |-> rxd);

  // R2: a detected falling edge yields space with a full count next cycle
  p_fall_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> (!rxd && cnt == CW'(BIT_CYCLES)));

  // R2: space only ever begins right after a detected falling edge
  p_space_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rxd) |-> $past(fall_evt));

  // R3: without a new edge a running count drops by exactly one
  p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall_evt && cnt != '0) |=> (cnt == $past(cnt) - CW'(1)));

  // R8: idle or rising input never produces space
  p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall_evt && cnt == '0) |=> rxd);

  // R7: a reload never leaves the count above one bit time
  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(BIT_CYCLES));
endmodule

bind sir_pulse_decoder sir_pulse_decoder_chk #(
  .BIT_CYCLES (BIT_CYCLES),
  .CW         (CW)
) u_chk (
  .clk      (clk_16x),
  .rst_n    (rst_n),
  .rxd      (rxd),
  .fall_evt (fall_evt),
  .cnt      (stretch_cnt)
);

// File: tb/sir_pulse_decoder_tb.sv
module sir_pulse_decoder_tb;
  localparam int BITC = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ir = 1'b1;
  logic rxd;

  int n_chk = 0, n_fail = 0;
  int st = 0;
  int f_last = -1000, f_prev = -1000;
  logic ir_q = 1'b1;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  sir_pulse_decoder #(.BIT_CYCLES(BITC)) u_dut (
    .clk_16x (clk),
    .rst_n   (rst_n),
    .ir_rx   (ir),
    .rxd     (rxd)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s step %0d: rxd=%b expected %b", req, st, act, exp);
    end
  endtask

  // Space is due from two to BITC+1 edges after the edge sampling a fall.
  function automatic logic model_rxd();
    int a = st - f_last;
    int b = st - f_prev;
    if ((a >= 2 && a <= BITC + 1) || (b >= 2 && b <= BITC + 1))
      return 1'b0;
    return 1'b1;
  endfunction

  task automatic tick(input logic v, input string req);
    if (ir_q && !v) begin
      f_prev = f_last;
      f_last = st + 1;
    end
    ir = v;
    ir_q = v;
    @(posedge clk);
    st++;
    @(negedge clk);
    check(req, rxd, model_rxd());
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) tick(1'b1, req);
  endtask

  task automatic do_reset(input string req);
    ir = 1'b1; ir_q = 1'b1;
    rst_n = 1'b0;
    #1;
    check(req, rxd, 1'b1);
    f_last = -1000; f_prev = -1000;
    @(posedge clk); st++;
    @(negedge clk);
    check(req, rxd, 1'b1);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();       // R1
    do_reset("R1");
    idle(5, "R1");
  endtask

  task automatic t_three_sixteenths(); // R2 R3 R4
    for (int i = 0; i < 3; i++) tick(1'b0, "R4");
    idle(24, "R3");
  endtask

  task automatic t_short_pulse();  // R5
    tick(1'b0, "R5");
    idle(24, "R5");
  endtask

  task automatic t_held_low();     // R6 then R8 on release
    for (int i = 0; i < 40; i++) tick(1'b0, "R6");
    idle(24, "R8");
  endtask

  task automatic t_back_to_back(); // R7
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < 3; i++) tick(1'b0, "R7");
      for (int i = 0; i < 13; i++) tick(1'b1, "R7");
    end
    tick(1'b0, "R7");
    idle(6, "R7");
    tick(1'b0, "R7");
    idle(24, "R7");
  endtask

  task automatic t_idle_line();    // R8
    idle(30, "R8");
  endtask

  task automatic t_reset_mid();    // R9
    tick(1'b0, "R9");
    idle(6, "R9");
    do_reset("R9");
    idle(24, "R9");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_idle_line();
    t_three_sixteenths();
    t_short_pulse();
    t_held_low();
    t_back_to_back();
    t_reset_mid();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule